// File: doc/BRIEF.md
# Transmit Descriptor Gather Engine

This block turns one transmit frame descriptor, held in a ring in host memory, into a single outgoing byte stream. Once started with a ring base and a slot index, it locates the 128-byte descriptor slot, reads the active-entry count, and decodes each buffer entry. An entry packs a 36-bit byte address and a 12-bit length into six little-endian bytes. The block then reads every buffer in entry order and emits the bytes with start and end markers. The frame is marked complete with a one-cycle done pulse.

All entries are decoded and checked before any payload is read. A descriptor with an illegal entry count, an empty or oversized buffer, or a frame total past the size limit is dropped with a one-cycle error pulse, and no byte reaches the output. Host memory is reached through a byte-wide read port. The block keeps exactly one read outstanding and accepts any response latency.

Top module: `txd_gather`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `mem_req`, `out_valid`, `done` and `err` are all low.
- R2: A `start` pulse while idle sets `busy`. The first read goes to `ring_base`*256 + `desc_idx`*128 + 3. Only bits 4:0 of the returned byte form the entry count; bits 7:5 are ignored.
- R3: An entry count of 0 or above 20 ends the descriptor after that single read, with `err` high for one cycle, no output byte and no `done`.
- R4: Entry k occupies descriptor bytes 4+6k to 9+6k. Bytes 0-3 are address bits 31:0, little-endian. Byte 4 bits 3:0 are address bits 35:32, and byte 4 bits 7:4 are length bits 3:0. Byte 5 holds length bits 11:4.
- R5: An entry length of 0 or above 4092 aborts the descriptor with `err` as soon as that entry's last byte is read, and no data is emitted. A length of exactly 4092 is accepted.
- R6: If the running sum of lengths passes 8192, the descriptor is aborted with `err` and no data is emitted. A total of exactly 8192 is accepted.
- R7: The output carries every buffer's bytes at ascending addresses, buffer after buffer in entry order. It holds exactly the summed length of bytes, each equal to memory contents.
- R8: `out_sof` is high with the first emitted byte only, and `out_eof` with the last only.
- R9: `done` pulses for one cycle in the same cycle as the `out_eof` byte, and `busy` is low in that cycle.
- R10: A `start` pulse while `busy` is high is ignored; the frame in progress completes unchanged.
- R11: At most one read is outstanding. A good descriptor with N entries and total length L takes exactly 1+6N+L reads.
- R12: `err` and `done` are never high together, and no output byte appears in an `err` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin processing one descriptor (taken only when idle) |
| ring_base | input | 28 | Ring base, byte address bits 35:8 |
| desc_idx | input | 8 | Descriptor slot within the ring |
| mem_req | output | 1 | One-cycle byte read request |
| mem_addr | output | 36 | Byte address of the request |
| mem_rdata | input | 8 | Returned byte |
| mem_ack | input | 1 | Returned byte is valid |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of the frame |
| out_eof | output | 1 | Last byte of the frame |
| done | output | 1 | Frame completed |
| err | output | 1 | Descriptor rejected |
| busy | output | 1 | Descriptor in progress |

## Verification
Each accepted read response produces its effect at the next clock edge. An output byte, a `done` pulse or an `err` pulse therefore becomes visible one cycle after the `mem_ack` that carried the deciding byte. The bench memory raises `mem_ack` one cycle after each request, so every byte costs two cycles. The checks never predict a cycle number. A monitor samples all outputs and requests at the falling edge, and each result is compared after `done` or `err` has been seen, plus a few quiet cycles. This still catches stray bytes, doubled pulses and extra reads.

// File: rtl/txg_pkg.sv
package txg_pkg;

    localparam int HADDR_W   = 36;
    localparam int BLEN_W    = 12;
    localparam int RBASE_W   = HADDR_W - 8;
    localparam int CNT_W     = 5;
    localparam int CNT_OFF   = 3;
    localparam int HDR_BYTES = 4;
    localparam int ENT_BYTES = 6;
    localparam int ENT_RAW_W = 8 * ENT_BYTES;

    typedef logic [HADDR_W-1:0] haddr_t;
    typedef logic [BLEN_W-1:0]  blen_t;

    typedef struct packed {
        haddr_t addr;
        blen_t  len;
    } bufent_t;

    typedef enum logic [1:0] {
        G_IDLE,
        G_HDR,
        G_ENT,
        G_DAT
    } gphase_t;

    // Six little-endian bytes: [35:0] byte address, [47:36] length.
    function automatic bufent_t decode_entry(input logic [ENT_RAW_W-1:0] raw);
        bufent_t e;
        e.addr = raw[HADDR_W-1:0];
        e.len  = raw[ENT_RAW_W-1:HADDR_W];
        return e;
    endfunction

    function automatic haddr_t ring_slot(input logic [RBASE_W-1:0] base,
                                         input haddr_t idx, input int shift);
        return {base, 8'h00} + (idx << shift);
    endfunction

endpackage

// File: rtl/txg_entry_table.sv
module txg_entry_table
    import txg_pkg::*;
#(
    parameter int DEPTH = 20,
    parameter int SEL_W = 5
) (
    input  logic             clk,
    input  logic             we,
    input  logic [SEL_W-1:0] widx,
    input  bufent_t          wdata,
    input  logic [SEL_W-1:0] ridx,
    output bufent_t          rdata
);

    bufent_t slot_view [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            bufent_t q;
            always_ff @(posedge clk) begin
                if (we && (widx == SEL_W'(g))) begin
                    q <= wdata;
                end
            end
            assign slot_view[g] = q;
        end
    endgenerate

    assign rdata = slot_view[ridx];

endmodule

// File: rtl/txg_len_check.sv
module txg_len_check
    import txg_pkg::*;
#(
    parameter int MAX_BUF   = 4092,
    parameter int MAX_FRAME = 8192,
    parameter int TOT_W     = 18
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  add_en,
    input  blen_t len,
    output logic  len_bad,
    output logic  frame_over
);

    localparam blen_t             BUF_LIM   = BLEN_W'(MAX_BUF);
    localparam logic [TOT_W-1:0]  FRAME_LIM = TOT_W'(MAX_FRAME);

    logic [TOT_W-1:0] total_q;
    logic [TOT_W-1:0] sum_next;

    always_comb begin
        sum_next   = total_q + TOT_W'(len);
        len_bad    = (len == '0) || (len > BUF_LIM);
        frame_over = sum_next > FRAME_LIM;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            total_q <= '0;
        end else if (add_en) begin
            total_q <= sum_next;
        end
    end

endmodule

// File: rtl/txd_gather.sv
module txd_gather
    import txg_pkg::*;
#(
    parameter int IDX_W      = 8,
    parameter int MAX_TBS    = 20,
    parameter int MAX_BUF    = 4092,
    parameter int MAX_FRAME  = 8192,
    parameter int SLOT_SHIFT = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [RBASE_W-1:0] ring_base,
    input  logic [IDX_W-1:0]   desc_idx,
    output logic               mem_req,
    output logic [HADDR_W-1:0] mem_addr,
    input  logic [7:0]         mem_rdata,
    input  logic               mem_ack,
    output logic               out_valid,
    output logic [7:0]         out_data,
    output logic               out_sof,
    output logic               out_eof,
    output logic               done,
    output logic               err,
    output logic               busy
);

    localparam int TBS_W = (MAX_TBS > 1) ? $clog2(MAX_TBS) : 1;
    localparam int TOT_W = $clog2(MAX_TBS * MAX_BUF + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_LIM  = CNT_W'(MAX_TBS);
    localparam logic [2:0]       SUB_LAST = 3'(ENT_BYTES - 1);

    gphase_t            phase;
    logic               pend;
    haddr_t             slot_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   ent_q;
    logic [2:0]         sub_q;
    logic [ENT_RAW_W-9:0] sh_q;
    blen_t              off_q;

    bufent_t new_ent;
    bufent_t cur_ent;
    logic    take;
    logic    last_entry;
    logic    buf_last;
    logic    ent_close;
    logic    len_bad;
    logic    frame_over;
    logic    tbl_we;
    logic    launch;

    always_comb begin
        take       = pend && mem_ack;
        launch     = (phase == G_IDLE) && start;
        new_ent    = decode_entry({mem_rdata, sh_q});
        last_entry = ent_q == (cnt_q - CNT_W'(1));
        buf_last   = off_q == (cur_ent.len - blen_t'(1));
        ent_close  = (phase == G_ENT) && take && (sub_q == SUB_LAST);
        tbl_we     = ent_close && !len_bad && !frame_over;
        busy       = phase != G_IDLE;
        mem_req    = (phase != G_IDLE) && !pend;
        case (phase)
            G_HDR:   mem_addr = slot_q + haddr_t'(CNT_OFF);
            G_ENT:   mem_addr = slot_q + haddr_t'(HDR_BYTES)
                              + haddr_t'(ent_q) * haddr_t'(ENT_BYTES)
                              + haddr_t'(sub_q);
            G_DAT:   mem_addr = cur_ent.addr + haddr_t'(off_q);
            default: mem_addr = '0;
        endcase
    end

    txg_entry_table #(
        .DEPTH (MAX_TBS),
        .SEL_W (TBS_W)
    ) u_table (
        .clk   (clk),
        .we    (tbl_we),
        .widx  (ent_q[TBS_W-1:0]),
        .wdata (new_ent),
        .ridx  (ent_q[TBS_W-1:0]),
        .rdata (cur_ent)
    );

    txg_len_check #(
        .MAX_BUF   (MAX_BUF),
        .MAX_FRAME (MAX_FRAME),
        .TOT_W     (TOT_W)
    ) u_len (
        .clk        (clk),
        .rst        (rst),
        .clr        (launch),
        .add_en     (tbl_we),
        .len        (new_ent.len),
        .len_bad    (len_bad),
        .frame_over (frame_over)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= G_IDLE;
            pend      <= 1'b0;
            slot_q    <= '0;
            cnt_q     <= '0;
            ent_q     <= '0;
            sub_q     <= '0;
            sh_q      <= '0;
            off_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;

            if (mem_req) begin
                pend <= 1'b1;
            end else if (take) begin
                pend <= 1'b0;
            end

            case (phase)
                G_IDLE: begin
                    if (start) begin
                        slot_q <= ring_slot(ring_base, haddr_t'(desc_idx), SLOT_SHIFT);
                        ent_q  <= '0;
                        sub_q  <= '0;
                        off_q  <= '0;
                        phase  <= G_HDR;
                    end
                end
                G_HDR: begin
                    if (take) begin
                        cnt_q <= mem_rdata[CNT_W-1:0];
                        if ((mem_rdata[CNT_W-1:0] == '0) ||
                            (mem_rdata[CNT_W-1:0] > CNT_LIM)) begin
                            err   <= 1'b1;
                            phase <= G_IDLE;
                        end else begin
                            phase <= G_ENT;
                        end
                    end
                end
                G_ENT: begin
                    if (take) begin
                        if (sub_q == SUB_LAST) begin
                            sub_q <= '0;
                            if (len_bad || frame_over) begin
                                err   <= 1'b1;
                                phase <= G_IDLE;
                            end else if (last_entry) begin
                                ent_q <= '0;
                                off_q <= '0;
                                phase <= G_DAT;
                            end else begin
                                ent_q <= ent_q + CNT_W'(1);
                            end
                        end else begin
                            sh_q  <= {mem_rdata, sh_q[ENT_RAW_W-9:8]};
                            sub_q <= sub_q + 3'd1;
                        end
                    end
                end
                G_DAT: begin
                    if (take) begin
                        out_valid <= 1'b1;
                        out_data  <= mem_rdata;
                        out_sof   <= (ent_q == '0) && (off_q == '0);
                        out_eof   <= buf_last && last_entry;
                        if (buf_last) begin
                            off_q <= '0;
                            if (last_entry) begin
                                done  <= 1'b1;
                                phase <= G_IDLE;
                            end else begin
                                ent_q <= ent_q + CNT_W'(1);
                            end
                        end else begin
                            off_q <= off_q + blen_t'(1);
                        end
                    end
                end
                default: phase <= G_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txg_checker.sv
module txg_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic mem_req,
    input logic out_valid,
    input logic out_sof,
    input logic out_eof,
    input logic done,
    input logic err
);

    assert_single_read_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    assert_req_only_busy_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    assert_markers_valid_R8: assert property (@(posedge clk) disable iff (rst)
        (out_sof || out_eof) |-> out_valid);

    assert_eof_done_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_eof) |-> (done && !busy));

    assert_done_eof_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (out_valid && out_eof));

    assert_err_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        err |-> (!out_valid && !done && !busy));

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

endmodule

bind txd_gather txg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .mem_req   (mem_req),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .done      (done),
    .err       (err)
);

// File: tb/sim_txd_gather.sv
module sim_txd_gather;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [27:0] ring_base = '0;
    logic [7:0]  desc_idx = '0;
    logic        mem_req;
    logic [35:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        out_valid, out_sof, out_eof, done, err, busy;
    logic [7:0]  out_data;

    always #4 clk = ~clk;

    txd_gather u0 (
        .clk(clk), .rst(rst), .start(start), .ring_base(ring_base), .desc_idx(desc_idx),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
        .done(done), .err(err), .busy(busy)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    bit [7:0] dmem [bit [35:0]];

    function automatic logic [7:0] memval(bit [35:0] a);
        if (dmem.exists(a)) return dmem[a];
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[35:32]} ^ 8'h3C;
    endfunction

    // Memory: answers each request one cycle later.
    logic        req_q = 1'b0;
    logic [35:0] addr_q = '0;
    always @(negedge clk) begin
        if (req_q) begin
            mem_ack   = 1'b1;
            mem_rdata = memval(addr_q);
        end else begin
            mem_ack = 1'b0;
        end
        req_q  = mem_req;
        addr_q = mem_addr;
    end

    // Monitor
    bit          mon_on = 0;
    logic [7:0]  got [$];
    int          sof_pos [$];
    int          eof_pos [$];
    int          dones, errs, reads, done_eof;
    logic [35:0] first_addr;
    bit          first_seen;
    always @(negedge clk) begin
        if (mon_on) begin
            if (mem_req) begin
                if (!first_seen) first_addr = mem_addr;
                first_seen = 1;
                reads++;
            end
            if (out_valid) begin
                if (out_sof) sof_pos.push_back(got.size());
                if (out_eof) eof_pos.push_back(got.size());
                got.push_back(out_data);
            end
            if (done) begin
                dones++;
                if (out_valid && out_eof) done_eof++;
            end
            if (err) errs++;
        end
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    logic [35:0] t_addr [20];
    int          t_len  [20];

    function automatic logic [35:0] slot_of(logic [27:0] b, logic [7:0] i);
        return {b, 8'h00} + (36'(i) << 7);
    endfunction

    task automatic put_desc(logic [27:0] b, logic [7:0] i, logic [7:0] cnt_byte, int n);
        logic [35:0] s;
        s = slot_of(b, i);
        dmem[s]     = 8'hA5;
        dmem[s + 1] = 8'h5A;
        dmem[s + 2] = 8'hC3;
        dmem[s + 3] = cnt_byte;
        for (int k = 0; k < n; k++) begin
            logic [35:0] e;
            e = s + 36'(4 + 6 * k);
            dmem[e]     = t_addr[k][7:0];
            dmem[e + 1] = t_addr[k][15:8];
            dmem[e + 2] = t_addr[k][23:16];
            dmem[e + 3] = t_addr[k][31:24];
            dmem[e + 4] = {4'(t_len[k] & 15), t_addr[k][35:32]};
            dmem[e + 5] = 8'((t_len[k] >> 4) & 255);
        end
    endtask

    // Runs one descriptor; exp_err selects the expected outcome.
    task automatic run(logic [27:0] b, logic [7:0] i, bit exp_err, int n,
                       int err_reads, string tag, bit poke);
        int w;
        int total;
        int mism;
        logic [7:0] exp_b [$];
        got.delete(); sof_pos.delete(); eof_pos.delete();
        dones = 0; errs = 0; reads = 0; done_eof = 0; first_seen = 0;
        mon_on = 1;
        @(negedge clk);
        ring_base = b; desc_idx = i; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (6) @(negedge clk);
            desc_idx = i + 8'd1; start = 1'b1;   // R10: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (dones == 0 && errs == 0 && w < 40000) begin
            @(negedge clk); #1;
            w++;
        end
        repeat (4) @(negedge clk);
        #1;
        mon_on = 0;
        chk(w < 40000, "R9", {tag, " completion"}, w, 0);
        chk(first_addr == slot_of(b, i) + 36'd3, "R2", {tag, " first read address"},
            longint'(first_addr), longint'(slot_of(b, i) + 36'd3));
        if (exp_err) begin
            chk(errs == 1 && dones == 0, tag, "error pulse", errs, 1);
            chk(got.size() == 0, "R12", {tag, " bytes after abort"}, got.size(), 0);
            chk(reads == err_reads, "R11", {tag, " reads before abort"}, reads, err_reads);
        end else begin
            total = 0;
            for (int k = 0; k < n; k++) begin
                for (int j = 0; j < t_len[k]; j++) exp_b.push_back(memval(t_addr[k] + 36'(j)));
                total += t_len[k];
            end
            chk(errs == 0, "R12", {tag, " unexpected error"}, errs, 0);
            chk(got.size() == total, "R7", {tag, " byte count"}, got.size(), total);
            mism = 0;
            for (int k = 0; k < got.size() && k < total; k++) if (got[k] !== exp_b[k]) mism++;
            chk(mism == 0, "R7", {tag, " data bytes (R4 decode)"}, mism, 0);
            chk(sof_pos.size() == 1 && sof_pos[0] == 0, "R8", {tag, " sof"},
                sof_pos.size(), 1);
            chk(eof_pos.size() == 1 && eof_pos[0] == total - 1, "R8", {tag, " eof"},
                eof_pos.size(), 1);
            chk(dones == 1 && done_eof == 1, "R9", {tag, " done with eof"}, done_eof, 1);
            chk(reads == 1 + 6 * n + total, "R11", {tag, " read count"}, reads,
                1 + 6 * n + total);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !out_valid && !done && !err, "R1", "in reset",
            {busy, mem_req, out_valid, done, err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req && !out_valid && !done && !err, "R1", "after reset",
            {busy, mem_req, out_valid, done, err}, 0);

        // Sweep of entry counts 1..20, count byte upper bits set (R2, R4, R7).
        for (int c = 1; c <= 20; c++) begin
            for (int k = 0; k < c; k++) begin
                t_addr[k] = {4'(c), 32'h8000_0000 + 32'(k * 4096 + c * 13)};
                t_len[k]  = 1 + (k * 5 + c) % 9;
            end
            put_desc(28'h0100000 + 28'(c * 3), 8'((c * 37) % 256), {3'(c), 5'(c)}, c);
            run(28'h0100000 + 28'(c * 3), 8'((c * 37) % 256), 0, c, 0, "sweep", 0);
        end

        // R3: illegal counts.
        put_desc(28'h0200000, 8'd5, 8'hE0, 0);
        run(28'h0200000, 8'd5, 1, 0, 1, "R3 count0", 0);
        put_desc(28'h0200000, 8'd6, 8'h15, 0);
        run(28'h0200000, 8'd6, 1, 0, 1, "R3 count21", 0);
        put_desc(28'h0200000, 8'd7, 8'h1F, 0);
        run(28'h0200000, 8'd7, 1, 0, 1, "R3 count31", 0);

        // R5: zero and oversize lengths, 4092 boundary.
        for (int k = 0; k < 3; k++) begin t_addr[k] = 36'h3_0000_0100 + 36'(k * 64); t_len[k] = 10; end
        t_len[1] = 0;
        put_desc(28'h0300000, 8'd255, 8'h03, 3);
        run(28'h0300000, 8'd255, 1, 3, 1 + 12, "R5 len0", 0);
        t_len[1] = 10; t_len[2] = 4093;
        put_desc(28'h0300000, 8'd254, 8'h03, 3);
        run(28'h0300000, 8'd254, 1, 3, 1 + 18, "R5 len4093", 0);
        t_addr[0] = 36'hF_FFFF_F800; t_len[0] = 4092;
        put_desc(28'h0ABCDEF, 8'd255, 8'h01, 1);
        run(28'h0ABCDEF, 8'd255, 0, 1, 0, "R5 len4092", 0);

        // R6: total boundary.
        t_addr[0] = 36'h4_0000_0000; t_len[0] = 4092;
        t_addr[1] = 36'h5_1234_5678; t_len[1] = 4092;
        t_addr[2] = 36'h6_0000_0FFD; t_len[2] = 9;
        put_desc(28'h0400000, 8'd9, 8'h03, 3);
        run(28'h0400000, 8'd9, 1, 3, 1 + 18, "R6 total8193", 0);
        t_len[2] = 8;
        put_desc(28'h0400000, 8'd10, 8'h03, 3);
        run(28'h0400000, 8'd10, 0, 3, 0, "R6 total8192", 0);

        // R10: second start while busy is ignored.
        t_addr[0] = 36'h7_0000_0000; t_len[0] = 3;
        t_addr[1] = 36'h7_0000_1000; t_len[1] = 4;
        put_desc(28'h0500000, 8'd21, 8'h02, 2);
        t_addr[0] = 36'h8_0000_0040; t_len[0] = 17;
        t_addr[1] = 36'h8_0000_2000; t_len[1] = 5;
        t_addr[2] = 36'h8_0000_3000; t_len[2] = 12;
        put_desc(28'h0500000, 8'd20, 8'h03, 3);
        run(28'h0500000, 8'd20, 0, 3, 0, "R10 restart", 1);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule